// File: doc/BRIEF.md
# Interrupt Request Capture Latch

This block turns a bank of raw interrupt lines into a vector of pending requests. Each line has its own trigger mode, held in a mode register that software can write. A line in level mode reports a request for as long as its input is high. A line in edge mode records a request when its input goes from low to high, and keeps that request until acknowledge logic clears it.

The mode register is loaded from a write port. A per-instance writable mask is applied to every write, so a line whose mask bit is zero stays in edge mode for good. The register can be read back on its own output. A separate initialization strobe clears the captured requests and the remembered input levels, and leaves the modes as they are.

All inputs are sampled on the rising clock edge. Every output is a register, so a change at the inputs shows up one cycle later. A pulse shorter than one clock period may be missed. Priority resolution and command decoding sit outside this block.

Top module: `irq_req_latch`

## Requirements
- R1: After reset deasserts, `pending` and `trig_mode` read all zero, so every line starts in edge mode.
- R2: A write with `trig_wr_en` high loads `trig_mode` with `trig_wr_data & WR_MASK` on the next edge. Bits that are clear in `WR_MASK` always read zero.
- R3: A line whose `trig_mode` bit is 1 (level mode) has its `pending` bit equal to its input from the previous cycle, set when high and cleared when low. The mode used for any cycle is the value `trig_mode` held before that edge.
- R4: A line whose `trig_mode` bit is 0 (edge mode) sets its `pending` bit one cycle after its input goes from low to high. An input held high does not set the bit again after it has been cleared.
- R5: On an edge-mode line, a low input does not clear `pending`. Only the remembered level is updated.
- R6: A high `ack_clr` bit clears `pending` on an edge-mode line on the next edge. On a level-mode line it has no effect.
- R7: When an edge-mode line sees a rising input in the same cycle as its `ack_clr` bit, the rising edge wins and `pending` ends up set.
- R8: `init_clr` clears all `pending` bits and all remembered levels on the next edge, and leaves `trig_mode` unchanged. After that, an edge-mode input that is still high counts as a fresh rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| init_clr | input | 1 | Initialization strobe: clears captured requests and remembered levels |
| irq_in | input | NUM_LINES | Raw interrupt input levels |
| ack_clr | input | NUM_LINES | Per-line acknowledge clear, used on edge-mode lines only |
| trig_wr_en | input | 1 | Write strobe for the trigger-mode register |
| trig_wr_data | input | NUM_LINES | Write data for the trigger-mode register (1 = level, 0 = edge) |
| trig_mode | output | NUM_LINES | Current trigger-mode register contents |
| pending | output | NUM_LINES | Pending request vector |

## Verification
The bench builds the block with eight lines and a writable mask of 8'hDE. With this mask, lines 0 and 5 cannot be switched out of edge mode even when a write of all ones is issued. The bench can therefore check the masking rule and a mixed edge/level vector in the same cycle. A pseudo-random stretch then walks every line through rising edges, acknowledge collisions and mode changes against a model built from the requirements.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;
    // Remembered input level of one line; a rising edge is a HIST_LOW state seeing a high input.
    typedef enum logic {
        HIST_LOW  = 1'b0,
        HIST_HIGH = 1'b1
    } line_hist_e;

    localparam int unsigned DEFAULT_LINES = 8;
endpackage

// File: rtl/trig_mode_reg.sv
module trig_mode_reg #(
    parameter int unsigned          WIDTH   = 8,
    parameter logic [WIDTH-1:0]     WR_MASK = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] mode_q
);
    logic [WIDTH-1:0] mode_d;

    always_comb begin
        mode_d = mode_q;
        if (wr_en) begin
            mode_d = wr_data & WR_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else begin
            mode_q <= mode_d;
        end
    end
endmodule

// File: rtl/irq_line_cell.sv
module irq_line_cell
    import irq_latch_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic init_clr,
    input  logic level_mode,
    input  logic raw_in,
    input  logic ack,
    output logic pend_q
);
    line_hist_e hist_q;
    line_hist_e hist_d;
    logic       rise;
    logic       pend_d;

    // Next history: follow the input; initialization forgets it.
    always_comb begin
        hist_d = raw_in ? HIST_HIGH : HIST_LOW;
        if (init_clr) begin
            hist_d = HIST_LOW;
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= HIST_LOW;
        end else begin
            hist_q <= hist_d;
        end
    end

    // Output logic: rising-edge detect and pending update.
    always_comb begin
        rise = 1'b0;
        unique case (hist_q)
            HIST_LOW:  rise = raw_in;
            HIST_HIGH: rise = 1'b0;
        endcase
        if (init_clr) begin
            pend_d = 1'b0;
        end else if (level_mode) begin
            pend_d = raw_in;
        end else begin
            pend_d = rise | (pend_q & ~ack);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else begin
            pend_q <= pend_d;
        end
    end
endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch
    import irq_latch_pkg::*;
#(
    parameter int unsigned              NUM_LINES = DEFAULT_LINES,
    parameter logic [NUM_LINES-1:0]     WR_MASK   = '1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 init_clr,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic [NUM_LINES-1:0] ack_clr,
    input  logic                 trig_wr_en,
    input  logic [NUM_LINES-1:0] trig_wr_data,
    output logic [NUM_LINES-1:0] trig_mode,
    output logic [NUM_LINES-1:0] pending
);
    trig_mode_reg #(
        .WIDTH   (NUM_LINES),
        .WR_MASK (WR_MASK)
    ) mode_reg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (trig_wr_en),
        .wr_data (trig_wr_data),
        .mode_q  (trig_mode)
    );

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        irq_line_cell cell_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .init_clr   (init_clr),
            .level_mode (trig_mode[g]),
            .raw_in     (irq_in[g]),
            .ack        (ack_clr[g]),
            .pend_q     (pending[g])
        );
    end
endmodule

// File: rtl/irq_req_latch_chk.sv
module irq_req_latch_chk #(
    parameter int unsigned          NUM_LINES = 8,
    parameter logic [NUM_LINES-1:0] WR_MASK   = '1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 init_clr,
    input logic [NUM_LINES-1:0] irq_in,
    input logic [NUM_LINES-1:0] ack_clr,
    input logic                 trig_wr_en,
    input logic [NUM_LINES-1:0] trig_wr_data,
    input logic [NUM_LINES-1:0] trig_mode,
    input logic [NUM_LINES-1:0] pending
);
    // Counts edges since reset, saturating at 2, so $past never reaches into reset.
    logic [1:0] arm_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arm_q <= 2'd0;
        end else if (arm_q != 2'd2) begin
            arm_q <= arm_q + 2'd1;
        end
    end

    assert_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_mode & ~WR_MASK) == '0);

    assert_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        trig_wr_en |=> trig_mode == $past(trig_wr_data & WR_MASK));

    assert_level_track_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_q != 2'd0 && !$past(init_clr)) |->
        ((pending & $past(trig_mode)) == ($past(irq_in) & $past(trig_mode))));

    assert_edge_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_q == 2'd2 && !$past(init_clr)) |->
        ((pending & $past(irq_in) & ~$past(irq_in, 2) & ~$past(trig_mode)) ==
         ($past(irq_in) & ~$past(irq_in, 2) & ~$past(trig_mode))));

    assert_edge_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_q != 2'd0 && !$past(init_clr)) |->
        ((pending & $past(pending) & ~$past(trig_mode) & ~$past(ack_clr)) ==
         ($past(pending) & ~$past(trig_mode) & ~$past(ack_clr))));

    assert_init_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_q != 2'd0 && $past(init_clr)) |-> pending == '0);

    assert_init_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_q != 2'd0 && $past(init_clr) && !$past(trig_wr_en)) |->
        trig_mode == $past(trig_mode));
endmodule

bind irq_req_latch irq_req_latch_chk #(
    .NUM_LINES (NUM_LINES),
    .WR_MASK   (WR_MASK)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .init_clr     (init_clr),
    .irq_in       (irq_in),
    .ack_clr      (ack_clr),
    .trig_wr_en   (trig_wr_en),
    .trig_wr_data (trig_wr_data),
    .trig_mode    (trig_mode),
    .pending      (pending)
);

// File: tb/irq_req_latch_tb_top.sv
`timescale 1ns/1ps
module irq_req_latch_tb_top;
    localparam int unsigned N    = 8;
    localparam logic [N-1:0] MSK = 8'hDE;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         init_clr = 1'b0;
    logic [N-1:0] irq_in = '0;
    logic [N-1:0] ack_clr = '0;
    logic         trig_wr_en = 1'b0;
    logic [N-1:0] trig_wr_data = '0;
    logic [N-1:0] trig_mode;
    logic [N-1:0] pending;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // Bench model state, derived from the requirements.
    logic [N-1:0] m_pend = '0;
    logic [N-1:0] m_last = '0;
    logic [N-1:0] m_trig = '0;

    logic [N-1:0] exp_pend_q[$];
    logic [N-1:0] exp_trig_q[$];
    string        tag_q[$];

    always #5 clk = ~clk;

    irq_req_latch #(.NUM_LINES(N), .WR_MASK(MSK)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .init_clr     (init_clr),
        .irq_in       (irq_in),
        .ack_clr      (ack_clr),
        .trig_wr_en   (trig_wr_en),
        .trig_wr_data (trig_wr_data),
        .trig_mode    (trig_mode),
        .pending      (pending)
    );

    task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: apply one cycle of stimulus, advance the model, queue the expectation.
    task automatic step(input logic [N-1:0] in, input logic [N-1:0] ack,
                        input logic wr, input logic [N-1:0] wd,
                        input logic ini, input string tag);
        logic [N-1:0] np;
        @(negedge clk);
        irq_in = in; ack_clr = ack; trig_wr_en = wr; trig_wr_data = wd; init_clr = ini;
        if (ini) begin
            np = '0;
            m_last = '0;
        end else begin
            np = (m_trig & in) | (~m_trig & ((in & ~m_last) | (m_pend & ~ack)));
            m_last = in;
        end
        m_pend = np;
        if (wr) m_trig = wd & MSK;
        exp_pend_q.push_back(m_pend);
        exp_trig_q.push_back(m_trig);
        tag_q.push_back(tag);
    endtask

    // Monitor: compare one queued item just after each edge.
    always @(posedge clk) begin
        #1;
        if (exp_pend_q.size() > 0) begin
            string t;
            logic [N-1:0] ep;
            logic [N-1:0] et;
            ep = exp_pend_q.pop_front();
            et = exp_trig_q.pop_front();
            t  = tag_q.pop_front();
            check({t, " pending"}, pending, ep);
            check({t, " trig_mode"}, trig_mode, et);
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset pending", pending, '0);
        check("R1 reset trig_mode", trig_mode, '0);

        step(8'h00, 8'h00, 0, 8'h00, 0, "R1 idle");
        // Edge behaviour on line 0.
        step(8'h01, 8'h00, 0, 8'h00, 0, "R4 rise sets");
        step(8'h01, 8'h00, 0, 8'h00, 0, "R4 held high");
        step(8'h01, 8'h01, 0, 8'h00, 0, "R6 ack clears edge");
        step(8'h01, 8'h00, 0, 8'h00, 0, "R4 no re-set while high");
        step(8'h00, 8'h00, 0, 8'h00, 0, "R5 low no effect");
        step(8'h01, 8'h00, 0, 8'h00, 0, "R4 second rise");
        step(8'h00, 8'h00, 0, 8'h00, 0, "R5 low keeps pending");
        step(8'h00, 8'h00, 0, 8'h00, 0, "R5 still pending");
        // Collision on line 1.
        step(8'h02, 8'h02, 0, 8'h00, 0, "R7 rise beats ack");
        step(8'h02, 8'h03, 0, 8'h00, 0, "R6 ack clears both");
        // Mode write with mask.
        step(8'h00, 8'h00, 1, 8'hFF, 0, "R2 masked write");
        step(8'h40, 8'h00, 0, 8'h00, 0, "R3 level high sets");
        step(8'h40, 8'h40, 0, 8'h00, 0, "R6 ack ignored on level");
        step(8'h00, 8'h00, 0, 8'h00, 0, "R3 level low clears");
        step(8'h21, 8'h00, 0, 8'h00, 0, "R2 unmasked lines stay edge");
        step(8'h00, 8'h00, 0, 8'h00, 0, "R5 edge lines keep");
        // Initialization clear.
        step(8'h81, 8'h00, 0, 8'h00, 1, "R8 init clears, keeps mode");
        step(8'h81, 8'h00, 0, 8'h00, 0, "R8 high edge input re-arms");
        step(8'h80, 8'h01, 1, 8'h00, 0, "R2 write to all-edge");
        step(8'h80, 8'h00, 0, 8'h00, 0, "R3 mode from before edge");

        lfsr = 16'hACE1;
        for (int n = 0; n < 48; n++) begin
            logic [N-1:0] a;
            logic [N-1:0] b;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            a = lfsr[7:0];
            b = lfsr[15:8] & lfsr[11:4];
            step(a, b, (n % 11) == 5, lfsr[12:5], (n % 17) == 9, "R3 R4 R6 R7 mixed");
        end
        step(8'h00, 8'h00, 0, 8'h00, 0, "R5 drain");
        repeat (3) @(negedge clk);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule